// File: doc/BRIEF.md
# Three-Wire Serial EEPROM Command Controller

This block is the master side of a three-wire serial EEPROM link for a memory of 16-bit words. A host presents one command at a time (read a word, write a word, erase a word, erase everything, fill everything, allow programming, forbid programming) with an 8-bit word address and a 16-bit data word. The controller turns the command into serial frames on a select line, a clock line and a data-out line, and samples a data-in line. On the board, data-out and data-in may be joined into one shared pin.

Every frame starts with a 1 and a two-bit opcode. Programming commands are not sent alone. The controller first unlocks the memory, then sends the operation, then polls the ready state at a fixed spacing until the memory reports ready or a poll budget runs out, and then locks the memory again. The host sees one busy period that ends in a single done pulse, with an error flag if the poll budget ran out. For a read, the word that was read is valid on that same pulse.

The serial clock is derived from the system clock through a half-period count taken from `div_i`. Each frame latches this count when the frame starts.

Top module: `mw_eeprom_ctrl`

## Requirements
- R1: Each frame is sent most significant bit first: a 1, then a two-bit opcode (10 read, 01 write, 11 erase, 00 special), then the 8-bit address. A write adds 16 data bits, so it is 27 clocks long. An erase is 11 clocks long.
- R2: Special frames use opcode 00. Address bits 7:6 select the operation: 11 unlock, 00 lock, 10 erase all, 01 fill all. Address bits 5:0 are sent as 0. A fill-all frame carries 16 data bits.
- R3: A read frame is 28 clocks long and data-out is 0 after the address. The first bit sampled after the address is a dummy and is discarded. The next 16 sampled bits, most significant first, appear on `rdata_o` in the cycle `done_o` is high.
- R4: Command codes (`cmd_op_i`) are 0 read, 1 write, 2 erase, 3 erase all, 4 fill all, 5 unlock, 6 lock, and 7 is treated as lock. Codes 1 to 4 run this sequence: unlock frame, operation frame, ready polls, lock frame.
- R5: A ready poll is one clock with select high, and the data-in value sampled on that clock is the result. A 1 ends polling. Consecutive polls, and the first poll after the operation frame, are separated by `POLL_WAIT` system cycles.
- R6: If `POLL_MAX` consecutive polls all read 0, the lock frame is still sent. The command then ends with `err_o` high in its `done_o` cycle. In every other case `err_o` is 0.
- R7: The clock line stays low while select is low. Select stays low for at least one serial clock period, 2*(div+1) system cycles, between any two frames.
- R8: The clock line stays in each half period for `div_i`+1 system cycles. Data-out changes only while the clock is low, and data-in is sampled where the clock rises.
- R9: A command is taken only when `cmd_valid_i` is high while `busy_o` is low. `cmd_valid_i` has no effect while busy. Each command ends with one `done_o` pulse of a single cycle, in the cycle where `busy_o` falls.
- R10: After reset, select, clock, data-out, `busy_o`, `done_o` and `err_o` are all 0.
- R11: Unlock and lock commands send exactly one frame of 11 clocks and do not poll.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | system clock |
| rst_ni | input | 1 | asynchronous reset, active low |
| div_i | input | DIV_W | serial half period minus one, in system cycles |
| cmd_valid_i | input | 1 | command request |
| cmd_op_i | input | 3 | command code (see R4) |
| cmd_addr_i | input | 8 | word address |
| cmd_wdata_i | input | 16 | data for write and fill all |
| busy_o | output | 1 | command in progress |
| done_o | output | 1 | one-cycle completion pulse |
| err_o | output | 1 | ready poll timed out (valid with done_o) |
| rdata_o | output | 16 | word returned by the last read |
| cs_o | output | 1 | memory select, active high |
| sk_o | output | 1 | serial clock |
| do_o | output | 1 | serial data to the memory |
| di_i | input | 1 | serial data from the memory |

## Verification
The bench drives a pin-level memory model. The model decodes every frame, keeps its own unlock state and contents, and answers polls after a programmed number of busy reads. The bench targets these cases:
- Busy counts of one below the poll budget and exactly at it. A controller with an off-by-one in the poll budget either reports a false timeout or polls once too often.
- A timeout. A controller that skips the lock frame on timeout leaves the memory unlocked, and the model catches that.
- Reads across several clock divisors. A controller that keeps the dummy bit returns every word shifted by one place.
- Commands pushed in while busy. A controller that accepts them sends extra frames.
- Commands with no unlock frame or a wrong special-code field. The model rejects these, so the next read back differs from the expected word.

// File: rtl/mw_ctrl_pkg.sv
package mw_ctrl_pkg;
  parameter int ADDR_W  = 8;
  parameter int DATA_W  = 16;
  localparam int CMD_W   = 3 + ADDR_W;
  localparam int FRAME_W = CMD_W + 1 + DATA_W;
  localparam int LEN_W   = $clog2(FRAME_W + 1);

  typedef enum logic [2:0] {
    OP_READ = 3'd0, OP_WRITE = 3'd1, OP_ERASE = 3'd2, OP_ERASE_ALL = 3'd3,
    OP_FILL_ALL = 3'd4, OP_UNLOCK = 3'd5, OP_LOCK = 3'd6, OP_LOCK_ALT = 3'd7
  } mw_op_e;

  typedef struct packed {
    logic [FRAME_W-1:0] bits;
    logic [LEN_W-1:0]   len;
  } mw_frame_t;

  function automatic logic is_prog(mw_op_e op);
    return (op == OP_WRITE) || (op == OP_ERASE) || (op == OP_ERASE_ALL) || (op == OP_FILL_ALL);
  endfunction

  // left-aligned frame: start bit, opcode, address, optional data, pad
  function automatic mw_frame_t build(mw_op_e op, logic [ADDR_W-1:0] addr, logic [DATA_W-1:0] data);
    mw_frame_t f;
    logic [ADDR_W-3:0] z;
    z = '0;
    case (op)
      OP_READ:      begin f.bits = {3'b110, addr, {(DATA_W+1){1'b0}}};       f.len = LEN_W'(FRAME_W); end
      OP_WRITE:     begin f.bits = {3'b101, addr, data, 1'b0};                f.len = LEN_W'(FRAME_W-1); end
      OP_ERASE:     begin f.bits = {3'b111, addr, {(DATA_W+1){1'b0}}};       f.len = LEN_W'(CMD_W); end
      OP_ERASE_ALL: begin f.bits = {3'b100, 2'b10, z, {(DATA_W+1){1'b0}}};   f.len = LEN_W'(CMD_W); end
      OP_FILL_ALL:  begin f.bits = {3'b100, 2'b01, z, data, 1'b0};           f.len = LEN_W'(FRAME_W-1); end
      OP_UNLOCK:    begin f.bits = {3'b100, 2'b11, z, {(DATA_W+1){1'b0}}};   f.len = LEN_W'(CMD_W); end
      default:      begin f.bits = {3'b100, 2'b00, z, {(DATA_W+1){1'b0}}};   f.len = LEN_W'(CMD_W); end
    endcase
    return f;
  endfunction

  function automatic mw_frame_t poll_frame();
    mw_frame_t f;
    f.bits = '0;
    f.len  = LEN_W'(1);
    return f;
  endfunction
endpackage

// File: rtl/mw_half_tick.sv
module mw_half_tick #(
  parameter int DIV_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             run_i,
  input  logic [DIV_W-1:0] div_i,
  output logic             tick_o
);
  logic [DIV_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                     cnt_q <= '0;
    else if (!run_i || cnt_q == div_i) cnt_q <= '0;
    else                             cnt_q <= cnt_q + 1'b1;
  end

  assign tick_o = run_i && (cnt_q == div_i);
endmodule

// File: rtl/mw_bit_engine.sv
module mw_bit_engine
  import mw_ctrl_pkg::*;
#(
  parameter int DIV_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  mw_frame_t         frame_i,
  input  logic [DIV_W-1:0]  div_i,
  output logic              cs_o,
  output logic              sk_o,
  output logic              do_o,
  input  logic              di_i,
  output logic [DATA_W-1:0] rx_o,
  output logic              done_o
);
  typedef enum logic [1:0] {E_IDLE, E_LOW, E_HIGH, E_GAP} eng_st_e;

  eng_st_e            st_q;
  logic [FRAME_W-1:0] sh_q;
  logic [LEN_W-1:0]   cnt_q;
  logic [DIV_W-1:0]   div_q;
  logic               gap_h_q, tick;

  mw_half_tick #(.DIV_W(DIV_W)) u_tick (
    .clk_i, .rst_ni, .run_i(st_q != E_IDLE), .div_i(div_q), .tick_o(tick)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q <= E_IDLE; cs_o <= 1'b0; sk_o <= 1'b0; do_o <= 1'b0;
      sh_q <= '0; cnt_q <= '0; div_q <= '0; gap_h_q <= 1'b0;
      rx_o <= '0; done_o <= 1'b0;
    end else begin
      done_o <= 1'b0;
      case (st_q)
        E_IDLE: if (start_i) begin
          cs_o  <= 1'b1;
          do_o  <= frame_i.bits[FRAME_W-1];
          sh_q  <= {frame_i.bits[FRAME_W-2:0], 1'b0};
          cnt_q <= frame_i.len;
          div_q <= div_i;
          st_q  <= E_LOW;
        end
        E_LOW: if (tick) begin
          sk_o <= 1'b1;
          rx_o <= {rx_o[DATA_W-2:0], di_i};
          st_q <= E_HIGH;
        end
        E_HIGH: if (tick) begin
          sk_o <= 1'b0;
          if (cnt_q == LEN_W'(1)) begin
            cs_o <= 1'b0; do_o <= 1'b0; gap_h_q <= 1'b0; st_q <= E_GAP;
          end else begin
            do_o  <= sh_q[FRAME_W-1];
            sh_q  <= {sh_q[FRAME_W-2:0], 1'b0};
            cnt_q <= cnt_q - 1'b1;
            st_q  <= E_LOW;
          end
        end
        default: if (tick) begin
          if (gap_h_q) begin st_q <= E_IDLE; done_o <= 1'b1; end
          else gap_h_q <= 1'b1;
        end
      endcase
    end
  end

  // checker state: select-low run length and divisor of the last frame
  logic [DIV_W+1:0] low_cnt_q;
  logic [DIV_W-1:0] prev_div_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      low_cnt_q <= '1; prev_div_q <= '0;
    end else if (cs_o) begin
      low_cnt_q <= '0; prev_div_q <= div_q;
    end else if (low_cnt_q != '1) begin
      low_cnt_q <= low_cnt_q + 1'b1;
    end
  end

  assert_sk_low_when_idle_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cs_o |-> !sk_o);
  assert_cs_gap_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(cs_o) |-> low_cnt_q >= (({2'b00, prev_div_q} + 1'b1) << 1));
  assert_do_stable_high_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sk_o |-> $stable(do_o));
endmodule

// File: rtl/mw_eeprom_ctrl.sv
module mw_eeprom_ctrl
  import mw_ctrl_pkg::*;
#(
  parameter int DIV_W     = 8,
  parameter int POLL_MAX  = 25,
  parameter int POLL_WAIT = 64
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [DIV_W-1:0]  div_i,
  input  logic              cmd_valid_i,
  input  logic [2:0]        cmd_op_i,
  input  logic [ADDR_W-1:0] cmd_addr_i,
  input  logic [DATA_W-1:0] cmd_wdata_i,
  output logic              busy_o,
  output logic              done_o,
  output logic              err_o,
  output logic [DATA_W-1:0] rdata_o,
  output logic              cs_o,
  output logic              sk_o,
  output logic              do_o,
  input  logic              di_i
);
  localparam int PC_W = $clog2(POLL_MAX + 1);
  localparam int WC_W = $clog2(POLL_WAIT + 1);

  typedef enum logic [2:0] {T_IDLE, T_EN, T_MAIN, T_WAIT, T_POLL, T_DIS} seq_st_e;

  seq_st_e           st_q;
  mw_op_e            op_q;
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] data_q;
  mw_frame_t         frame_q;
  logic              start_q, eng_done, timeout_q;
  logic [DATA_W-1:0] rx;
  logic [PC_W-1:0]   poll_cnt_q;
  logic [WC_W-1:0]   wait_cnt_q;

  mw_bit_engine #(.DIV_W(DIV_W)) u_eng (
    .clk_i, .rst_ni, .start_i(start_q), .frame_i(frame_q), .div_i,
    .cs_o, .sk_o, .do_o, .di_i, .rx_o(rx), .done_o(eng_done)
  );

  assign busy_o = (st_q != T_IDLE);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q <= T_IDLE; op_q <= OP_READ; addr_q <= '0; data_q <= '0;
      frame_q <= '0; start_q <= 1'b0; timeout_q <= 1'b0;
      poll_cnt_q <= '0; wait_cnt_q <= '0;
      done_o <= 1'b0; err_o <= 1'b0; rdata_o <= '0;
    end else begin
      start_q <= 1'b0;
      done_o  <= 1'b0;
      err_o   <= 1'b0;
      case (st_q)
        T_IDLE: if (cmd_valid_i) begin
          op_q <= mw_op_e'(cmd_op_i); addr_q <= cmd_addr_i; data_q <= cmd_wdata_i;
          poll_cnt_q <= '0; timeout_q <= 1'b0; start_q <= 1'b1;
          if (is_prog(mw_op_e'(cmd_op_i))) begin
            frame_q <= build(OP_UNLOCK, '0, '0); st_q <= T_EN;
          end else begin
            frame_q <= build(mw_op_e'(cmd_op_i), cmd_addr_i, cmd_wdata_i); st_q <= T_MAIN;
          end
        end
        T_EN: if (eng_done) begin
          frame_q <= build(op_q, addr_q, data_q); start_q <= 1'b1; st_q <= T_MAIN;
        end
        T_MAIN: if (eng_done) begin
          if (is_prog(op_q)) begin
            wait_cnt_q <= '0; st_q <= T_WAIT;
          end else begin
            if (op_q == OP_READ) rdata_o <= rx;
            done_o <= 1'b1; st_q <= T_IDLE;
          end
        end
        T_WAIT: begin
          wait_cnt_q <= wait_cnt_q + 1'b1;
          if (wait_cnt_q == WC_W'(POLL_WAIT - 1)) begin
            frame_q <= poll_frame(); start_q <= 1'b1; st_q <= T_POLL;
          end
        end
        T_POLL: if (eng_done) begin
          if (rx[0] || poll_cnt_q == PC_W'(POLL_MAX - 1)) begin
            timeout_q <= !rx[0];
            frame_q <= build(OP_LOCK, '0, '0); start_q <= 1'b1; st_q <= T_DIS;
          end else begin
            poll_cnt_q <= poll_cnt_q + 1'b1; wait_cnt_q <= '0; st_q <= T_WAIT;
          end
        end
        default: if (eng_done) begin
          done_o <= 1'b1; err_o <= timeout_q; st_q <= T_IDLE;
        end
      endcase
    end
  end

  assert_err_only_with_done_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |-> done_o);
  assert_poll_budget_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    poll_cnt_q < PC_W'(POLL_MAX));
  assert_done_ends_busy_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> ($past(busy_o) && !busy_o));
  assert_accept_on_valid_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_o) |-> $past(cmd_valid_i));
  assert_select_within_cmd_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cs_o |-> busy_o);
endmodule

// File: tb/tb_mw_eeprom_ctrl.sv
module tb_mw_eeprom_ctrl;
  localparam int DIV_W = 4;
  localparam int PMAX  = 5;
  localparam int PWAIT = 10;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [DIV_W-1:0] div = '0;
  logic cmd_valid = 1'b0;
  logic [2:0] cmd_op = '0;
  logic [7:0] cmd_addr = '0;
  logic [15:0] cmd_wdata = '0;
  logic busy, done, err, cs, sk, dout, din;
  logic [15:0] rdata;

  always #2 clk = ~clk;

  mw_eeprom_ctrl #(.DIV_W(DIV_W), .POLL_MAX(PMAX), .POLL_WAIT(PWAIT)) dut (
    .clk_i(clk), .rst_ni(rst_n), .div_i(div), .cmd_valid_i(cmd_valid), .cmd_op_i(cmd_op),
    .cmd_addr_i(cmd_addr), .cmd_wdata_i(cmd_wdata), .busy_o(busy), .done_o(done), .err_o(err),
    .rdata_o(rdata), .cs_o(cs), .sk_o(sk), .do_o(dout), .di_i(din)
  );

  // pin-level memory model
  logic [15:0] mem [256];
  logic [31:0] sh = '0;
  int n = 0, nf = 0, polls_left = 0, busy_cfg = 0;
  int flog [2048];
  bit we = 1'b0, reading = 1'b0, rd_bit = 1'b0;
  logic [7:0] rd_addr = '0;
  int cyc = 0, fall_cyc = 0, rise_cyc = 0, fall_div = 0;
  bit have_fall = 1'b0, seen_rise = 1'b0;
  int gap_bad = 0, half_bad = 0;

  assign din = reading ? rd_bit : (polls_left == 0);

  always @(posedge clk) cyc++;

  always @(posedge sk or negedge cs) begin
    if (cs && sk) begin
      sh = {sh[30:0], dout}; n++;
      rise_cyc = cyc; seen_rise = 1'b1;
      if (n == 11 && sh[10:8] == 3'b110) begin reading = 1'b1; rd_addr = sh[7:0]; rd_bit = 1'b0; end
      else if (reading && n >= 12 && n <= 27) rd_bit = mem[rd_addr][27-n];
    end else if (!cs) begin
      int kind;
      logic [10:0] c;
      kind = 0;
      if (n == 1) begin
        kind = 8; if (polls_left > 0) polls_left--;
      end else if (n >= 11) begin
        c = 11'(sh >> (n - 11));
        if (c[10]) case (c[9:8])
          2'b10: if (n == 28) kind = 7;
          2'b01: if (n == 27) begin kind = 5; if (we) mem[c[7:0]] = sh[15:0]; polls_left = busy_cfg; end
          2'b11: if (n == 11) begin kind = 6; if (we) mem[c[7:0]] = 16'hFFFF; polls_left = busy_cfg; end
          default: if (c[5:0] == 6'd0) case (c[7:6])
            2'b11: if (n == 11) begin kind = 1; we = 1'b1; end
            2'b00: if (n == 11) begin kind = 2; we = 1'b0; end
            2'b10: if (n == 11) begin
              kind = 3; polls_left = busy_cfg;
              if (we) for (int i = 0; i < 256; i++) mem[i] = 16'hFFFF;
            end
            default: if (n == 27) begin
              kind = 4; polls_left = busy_cfg;
              if (we) for (int i = 0; i < 256; i++) mem[i] = sh[15:0];
            end
          endcase
        endcase
      end
      if (n > 0) begin
        flog[nf] = kind; nf++;
        fall_cyc = cyc; fall_div = int'(div); have_fall = 1'b1;
      end
      n = 0; sh = '0; reading = 1'b0;
    end
  end

  always @(posedge cs) if (have_fall && (cyc - fall_cyc) < 2 * (fall_div + 1)) gap_bad++;
  always @(negedge sk) if (seen_rise && (cyc - rise_cyc) != int'(div) + 1) half_bad++;

  int n_chk = 0, n_bad = 0;
  logic [15:0] exp_mem [256];

  task automatic chk(input bit ok, input string req, input int act, input int expv);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
    end
  endtask

  function automatic int op_kind(input logic [2:0] op);
    case (op)
      3'd0: return 7; 3'd1: return 5; 3'd2: return 6; 3'd3: return 3;
      3'd4: return 4; 3'd5: return 1; default: return 2;
    endcase
  endfunction

  function automatic bit prog(input logic [2:0] op);
    return op >= 3'd1 && op <= 3'd4;
  endfunction

  function automatic int exp_polls(input int bp);
    return (bp < PMAX) ? bp + 1 : PMAX;
  endfunction

  task automatic exp_update(input logic [2:0] op, input logic [7:0] a, input logic [15:0] d);
    case (op)
      3'd1: exp_mem[a] = d;
      3'd2: exp_mem[a] = 16'hFFFF;
      3'd3: for (int i = 0; i < 256; i++) exp_mem[i] = 16'hFFFF;
      3'd4: for (int i = 0; i < 256; i++) exp_mem[i] = d;
      default: ;
    endcase
  endtask

  logic [15:0] got_rd;
  logic got_err;

  task automatic run_cmd(input logic [2:0] op, input logic [7:0] a, input logic [15:0] d,
                         input int bp, input bit poke, input string req);
    int first, k, wd;
    busy_cfg = bp; first = nf;
    @(negedge clk);
    cmd_valid = 1'b1; cmd_op = op; cmd_addr = a; cmd_wdata = d;
    @(negedge clk);
    cmd_valid = 1'b0;
    chk(busy == 1'b1, "R9 busy after accept", busy, 1);
    if (poke) begin
      cmd_valid = 1'b1; cmd_op = 3'd3;
      repeat (4) @(negedge clk);
      cmd_valid = 1'b0;
    end
    wd = 0;
    while (!done && wd < 40000) begin @(negedge clk); wd++; end
    chk(wd < 40000, "R9 watchdog", wd, 0);
    got_rd = rdata; got_err = err;
    @(negedge clk);
    chk(done == 1'b0 && busy == 1'b0, "R9 single done pulse", {done, busy}, 0);
    exp_update(op, a, d);
    // frame sequence
    k = first;
    if (prog(op)) begin
      chk(flog[k] == 1, {req, " unlock first R4"}, flog[k], 1); k++;
      chk(flog[k] == op_kind(op), {req, " op frame R1 R2"}, flog[k], op_kind(op)); k++;
      for (int p = 0; p < exp_polls(bp); p++) begin
        chk(flog[k] == 8, {req, " poll R5"}, flog[k], 8); k++;
      end
      chk(flog[k] == 2, {req, " lock last R4"}, flog[k], 2); k++;
      chk(we == 1'b0, "R4 memory locked after sequence", we, 0);
      chk(got_err == (bp >= PMAX), "R6 err flag", got_err, bp >= PMAX);
    end else begin
      chk(flog[k] == op_kind(op), {req, " single frame R11 R1"}, flog[k], op_kind(op)); k++;
      chk(got_err == 1'b0, "R6 no err", got_err, 0);
    end
    chk(nf == k, {req, " frame count"}, nf - first, k - first);
  endtask

  initial begin
    int seed;
    seed = $urandom(32'h5eed);
    repeat (3) @(negedge clk);
    chk({cs, sk, dout, busy, done, err} == 6'd0, "R10 reset state", {cs, sk, dout, busy, done, err}, 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk({cs, sk, dout, busy, done, err} == 6'd0, "R10 idle after reset", {cs, sk, dout, busy, done, err}, 0);

    run_cmd(3'd5, 8'h00, 16'h0, 0, 1'b0, "R11 unlock");
    chk(we == 1'b1, "R2 unlock decoded", we, 1);
    run_cmd(3'd6, 8'h00, 16'h0, 0, 1'b0, "R11 lock");
    chk(we == 1'b0, "R2 lock decoded", we, 0);
    run_cmd(3'd4, 8'h00, 16'h0000, 0, 1'b0, "R2 fill zero");
    div = 4'd2;
    run_cmd(3'd1, 8'hA5, 16'hC3E1, 2, 1'b0, "R1 write");
    run_cmd(3'd0, 8'hA5, 16'h0, 0, 1'b0, "R3 read");
    chk(got_rd == 16'hC3E1, "R3 read data", got_rd, 16'hC3E1);
    run_cmd(3'd0, 8'h5A, 16'h0, 0, 1'b0, "R3 read zero");
    chk(got_rd == 16'h0000, "R3 untouched word", got_rd, 0);
    run_cmd(3'd2, 8'hA5, 16'h0, 0, 1'b0, "R1 erase");
    run_cmd(3'd0, 8'hA5, 16'h0, 0, 1'b0, "R3 read erased");
    chk(got_rd == 16'hFFFF, "R3 erased word", got_rd, 16'hFFFF);
    div = 4'd0;
    run_cmd(3'd1, 8'h01, 16'h8001, PMAX - 1, 1'b0, "R5 last poll ready");
    run_cmd(3'd1, 8'h02, 16'h7FFE, PMAX, 1'b0, "R6 timeout");
    run_cmd(3'd0, 8'h02, 16'h0, 0, 1'b0, "R3 read after timeout");
    chk(got_rd == 16'h7FFE, "R3 data after timeout", got_rd, 16'h7FFE);
    run_cmd(3'd7, 8'h00, 16'h0, 0, 1'b0, "R4 code7 lock");
    div = 4'd3;
    run_cmd(3'd1, 8'h10, 16'h1234, 1, 1'b1, "R9 poke while busy");
    repeat (60) @(negedge clk);
    run_cmd(3'd0, 8'h10, 16'h0, 0, 1'b0, "R9 read after poke");
    chk(got_rd == 16'h1234, "R9 poke ignored", got_rd, 16'h1234);
    run_cmd(3'd0, 8'h20, 16'h0, 0, 1'b0, "R9 other word");
    chk(got_rd == 16'h0000, "R9 no erase-all from poke", got_rd, 0);
    run_cmd(3'd3, 8'h00, 16'h0, 0, 1'b0, "R2 erase all");
    run_cmd(3'd4, 8'h3C, 16'hBEEF, 1, 1'b0, "R2 fill all");
    run_cmd(3'd0, 8'hFF, 16'h0, 0, 1'b0, "R2 read fill");
    chk(got_rd == 16'hBEEF, "R2 fill value", got_rd, 16'hBEEF);

    for (int it = 0; it < 40; it++) begin
      logic [2:0] op;
      logic [7:0] a;
      int r;
      r = int'($urandom_range(0, 2));
      op = (r == 0) ? 3'd0 : (r == 1) ? 3'd1 : 3'd2;
      a = 8'($urandom_range(0, 7) * 37);
      div = DIV_W'($urandom_range(0, 3));
      run_cmd(op, a, 16'($urandom), int'($urandom_range(0, 3)), 1'b0, "random");
      if (op == 3'd0) chk(got_rd == exp_mem[a], "R3 random read", got_rd, exp_mem[a]);
    end

    chk(gap_bad == 0, "R7 select gap", gap_bad, 0);
    chk(half_bad == 0, "R8 half period", half_bad, 0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule